// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier with Ripple Row Summation

This block multiplies two 8-bit two's-complement operands and produces the full 16-bit signed product. The multiplier operand is recoded into radix-4 Booth digits. Each digit selects zero, the multiplicand, twice the multiplicand, or the negative of either. Each bit of a partial-product row comes from a small selector: pick the bit of the single multiple or the bit of the doubled multiple, then XOR it with the negate flag.

The recoding gives half as many rows as the multiplier has bits. Those rows are added in a linear chain of ripple-carry adders. The adder for row i covers only bit 2·i and the bits above it. The negate flag of that row enters as the adder's carry-in, which completes the two's complement of an inverted multiple. The chain result is captured in one output register. A product therefore appears on the clock edge after its operands are presented, and a new operand pair can be accepted every cycle.

Top module: `booth_mult_rca`

## Requirements
- R1: While rst_ni is low, prod_o is 0. Asserting rst_ni clears prod_o at once, without waiting for a clock edge.
- R2: After each rising clk_i edge with rst_ni high, prod_o equals the signed product of the mcand_i and mplier_i values sampled at that edge. The product is given as a 16-bit two's-complement value.
- R3: Recoding starts from an implied 0 placed below bit 0 of mplier_i. Digit 0 is therefore formed from mplier_i[1:0] and that 0, so a multiplier of +1 returns the multiplicand unchanged.
- R4: Digit i is formed from the three bits {mplier_i[2i+1], mplier_i[2i], mplier_i[2i-1]} and equals -2·mplier_i[2i+1] + mplier_i[2i] + mplier_i[2i-1]. At most one of the single-multiple select and the doubled-multiple select is active for a digit.
- R5: An 8-bit multiplier yields exactly 4 digits, and digit 3 carries weight 64. A multiplier of -128 (group 100 in digit 3, zero elsewhere) returns -128 times the multiplicand.
- R6: For a digit of ±2, row bit j is taken from multiplicand bit j-1, with 0 at j = 0. A multiplier of +2 returns twice the multiplicand.
- R7: For a digit of -1 or -2, the selected multiple is inverted bit by bit and a 1 is added at bit 2·i as the carry-in of that row's adder. Negative multipliers therefore give correct products.
- R8: Groups 000 and 111 give a zero digit. For a zero digit the row is all zeros and the negate flag is clear, so a multiplier of 0 or -1 adds nothing spurious.
- R9: The extreme operand -128 is handled in both positions. For example, -128 × -128 returns 16384 and -128 × 127 returns -16256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the product register samples on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcand_i | input | 8 | Multiplicand, two's complement |
| mplier_i | input | 8 | Multiplier, two's complement, recoded into Booth digits |
| prod_o | output | 16 | Registered signed product |

## Verification
The bench targets the following corner cases:
- A multiplier of 0 or -1. A design that does not clear the row or the negate flag for groups 000 and 111 adds a stray one at bit 2·i.
- A multiplier of +1. If the implied zero below bit 0 is missing, this case goes wrong.
- Multipliers of +2 and -128. A misplaced doubling shift or a dropped top digit breaks these.
- A multiplicand of -128. This case exposes a row that is not sign-extended correctly when its multiple is doubled or inverted.

All 65536 operand pairs are compared, so any error in a selector bit or carry position shows up as a wrong product.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // one Booth digit: magnitude select (x1 / x2) and sign
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } digit_t;
endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_pkg::*;
(
  input  logic [2:0] grp_i,
  output digit_t     dig_o
);
  // digit = -2*grp[2] + grp[1] + grp[0]
  always_comb begin
    dig_o.one = grp_i[1] ^ grp_i[0];
    dig_o.two = (grp_i == 3'b100) || (grp_i == 3'b011);
    dig_o.neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);
  end
endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 16   // row width from bit 2*i upward
) (
  input  logic [W-1:0] x_i,
  input  digit_t       dig_i,
  output logic [N-1:0] row_o
);
  localparam int EXT = N - W - 1;

  logic [W:0] xe;
  logic [W:0] pp;

  assign xe = {x_i[W-1], x_i};

  for (genvar j = 0; j <= W; j++) begin : g_bit
    if (j == 0) begin : g_lsb
      assign pp[j] = (xe[j] & dig_i.one) ^ dig_i.neg;
    end else begin : g_mid
      assign pp[j] = ((xe[j] & dig_i.one) | (xe[j-1] & dig_i.two)) ^ dig_i.neg;
    end
  end

  assign row_o = {{EXT{pp[W]}}, pp};

  always_comb begin
    p_sel_onehot_r4: assert ($onehot0({dig_i.one, dig_i.two}));
    if (!dig_i.one && !dig_i.two) begin
      p_zero_row_r8: assert (row_o == '0 && !dig_i.neg);
    end
  end
endmodule

// File: rtl/rca_add.sv
module rca_add #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         ci_i,
  output logic [N-1:0] s_o
);
  logic [N-1:0] c;

  assign c[0] = ci_i;

  for (genvar j = 0; j < N; j++) begin : g_fa
    assign s_o[j] = a_i[j] ^ b_i[j] ^ c[j];
    if (j < N - 1) begin : g_cy
      assign c[j+1] = (a_i[j] & b_i[j]) | (c[j] & (a_i[j] ^ b_i[j]));
    end
  end
endmodule

// File: rtl/booth_mult_rca.sv
module booth_mult_rca
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      mcand_i,
  input  logic [W-1:0]      mplier_i,
  output logic [2*W-1:0]    prod_o
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W / 2;

  logic [W:0]              ye;   // multiplier with implied 0 below LSB
  digit_t [ROWS-1:0]       dig;
  logic [ROWS:0][PW-1:0]   acc;
  logic [PW-1:0]           prod_q;

  assign ye     = {mplier_i, 1'b0};
  assign acc[0] = '0;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int LO = 2 * i;
    localparam int N  = PW - LO;

    logic [N-1:0] row;

    booth_digit_enc u_enc (
      .grp_i (ye[LO+2:LO]),
      .dig_o (dig[i])
    );

    booth_pp_row #(.W(W), .N(N)) u_row (
      .x_i   (mcand_i),
      .dig_i (dig[i]),
      .row_o (row)
    );

    // neg of row i enters at bit 2*i as carry-in
    rca_add #(.N(N)) u_add (
      .a_i  (acc[i][PW-1:LO]),
      .b_i  (row),
      .ci_i (dig[i].neg),
      .s_o  (acc[i+1][PW-1:LO])
    );

    if (LO > 0) begin : g_pass
      assign acc[i+1][LO-1:0] = acc[i][LO-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= acc[ROWS];
  end

  assign prod_o = prod_q;

  p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |-> prod_o == '0);

  p_product_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $signed(prod_o) == $signed($past(mcand_i)) * $signed($past(mplier_i)));
endmodule

// File: tb/sim_booth_mult_rca.sv
module sim_booth_mult_rca;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] p;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  booth_mult_rca u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .mcand_i  (a),
    .mplier_i (b),
    .prod_o   (p)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req,
               $signed(a), $signed(b), $signed(act), $signed(exp));
    end
  endtask

  function automatic string tag_of(input logic signed [7:0] sa, input logic signed [7:0] sb);
    if (sa == -8'sd128)                  return "R9";
    if (sb == 8'sd0 || sb == -8'sd1)     return "R8";  // zero-digit groups
    if (sb == 8'sd1)                     return "R3";  // implied zero below LSB
    if (sb == 8'sd2)                     return "R6";  // doubled multiple
    if (sb == -8'sd128)                  return "R5";  // top digit only
    if (sb < 0)                          return "R7";  // negate path
    if (sb[0])                           return "R4";
    return "R2";
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", p, 16'd0);
    rst_n = 1'b1;
    for (int ia = -128; ia < 128; ia++) begin
      for (int ib = -128; ib < 128; ib++) begin
        int e;
        @(negedge clk);
        a = 8'(ia);
        b = 8'(ib);
        e = ia * ib;
        @(negedge clk);
        check(tag_of(8'(ia), 8'(ib)), p, e[15:0]);
      end
    end
    // R9 explicit extremes
    @(negedge clk); a = 8'h80; b = 8'h80;
    @(negedge clk); check("R9", p, 16'd16384);
    // R1: asynchronous clear mid-run
    a = 8'h7f; b = 8'h7f;
    @(negedge clk); check("R2", p, 16'd16129);
    #1 rst_n = 1'b0;
    #0.5 check("R1", p, 16'd0);
    @(negedge clk); check("R1", p, 16'd0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule